// File: doc/BRIEF.md
# Wallace Tree Carry-Save Multiplier

This block multiplies two unsigned operands, an N-bit `opA` and an M-bit `opB` (8 by 8 by default), and returns the full (N+M)-bit product. Every multiplier bit gates the multiplicand to form one shifted partial-product row. The rows are then thinned level by level. In each level, groups of three rows of equal weight pass through 3:2 carry-save adders, and each adder gives back a sum row and a carry row. The carry row moves one bit position up before it reaches the next level. Rows left over after grouping go through the level unchanged. When two rows remain, one ordinary adder resolves the carries and produces the product.

The parameter `PIPE` picks one of two variants. With `PIPE=1`, a register bank sits behind every reduction level and one more sits behind the final adder. A qualifier bit, `validIn`, travels beside the data. A small control module turns that qualifier into per-stage load strobes, so stage registers change only when a real operand pair passes through them. With `PIPE=0` the whole path is combinational, and `validOut` simply mirrors `validIn`. Operands that arrive with the qualifier low are treated as garbage.

Top module: `wallace_mul`

## Requirements
- R1: For every operand pair accepted with `validIn` high, the result presented with `validOut` high equals opA*opB as an unsigned (N+M)-bit value. This includes zero, all-ones and single-bit operands.
- R2: With PIPE=1, `validOut` rises exactly L+1 clock edges after the edge that samples `validIn` high. L is the number of reduction levels, found by starting from R=max(M,3) rows and repeatedly replacing R with 2*floor(R/3)+(R mod 3) until R is 2. The default 8x8 gives L=4 and a latency of 5.
- R3: With PIPE=1, a new operand pair can be accepted on every clock edge. Results come out in acceptance order, and any gaps in `validIn` appear as the same gaps in `validOut`.
- R4: With PIPE=1, while `validOut` is low, `product` keeps the last valid result.
- R5: While `rstN` is low, and on the first edge after it is released, `validOut` is 0 and `product` is 0.
- R6: With PIPE=0, `product` equals opA*opB and `validOut` equals `validIn` in the same cycle, with no clock edge involved.
- R7: With PIPE=1, operand values presented while `validIn` is low never show up at the output. They neither raise `validOut` nor change `product`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Qualifies opA and opB in this cycle |
| opA | input | N | Unsigned multiplicand |
| opB | input | M | Unsigned multiplier; each bit forms one partial-product row |
| validOut | output | 1 | Qualifies product |
| product | output | N+M | Unsigned product |

## Verification
In the pipelined variant, one clock edge can finish an earlier operand pair at the output while the input stage either takes in a new pair or sees garbage with `validIn` low. The bench provokes this with a back-to-back stream of random and corner operands broken by bubbles, and puts deliberately different operand values on the bus during each bubble. On every cycle it compares `validOut` and `product` against a queue built from the requirements. A result has to match its own pair. A bubble has to appear as `validOut` low with the previous product held, and the garbage values must not leak into it.

// File: rtl/wallace_pkg.sv
package wallace_pkg;

  localparam int MAX_STAGES = 32;

  // load strobes from control to datapath, one per register bank
  typedef struct packed {
    logic [MAX_STAGES-1:0] loadEn;
  } strobe_t;

  // rows left after one 3:2 level
  function automatic int rowsAfter(input int r);
    return 2 * (r / 3) + (r % 3);
  endfunction

  function automatic int rowsAtLevel(input int m, input int l);
    int r;
    r = m;
    for (int i = 0; i < l; i++) r = rowsAfter(r);
    return r;
  endfunction

  function automatic int levelCount(input int m);
    int r;
    int n;
    r = m;
    n = 0;
    while (r > 2) begin
      r = rowsAfter(r);
      n++;
    end
    return n;
  endfunction

  // tree is always built on at least three rows
  function automatic int padRows(input int m);
    return (m < 3) ? 3 : m;
  endfunction

endpackage

// File: rtl/wallace_csa.sv
module wallace_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] sumRow,
  output logic [W-1:0] carryRow
);

  logic [W-1:0] majority;

  assign sumRow   = inA ^ inB ^ inC;
  assign majority = (inA & inB) | (inA & inC) | (inB & inC);
  // carries weigh one position more; top bit drops out of the product width
  assign carryRow = {majority[W-2:0], 1'b0};

endmodule

// File: rtl/wallace_datapath.sv
module wallace_datapath
  import wallace_pkg::*;
#(
  parameter int N    = 8,
  parameter int M    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   opA,
  input  logic [M-1:0]   opB,
  input  strobe_t        strobes,
  output logic [N+M-1:0] product
);

  localparam int W    = N + M;
  localparam int PPR  = padRows(M);
  localparam int LVLS = levelCount(PPR);

  logic [W-1:0] ppRows [PPR];
  logic [W-1:0] sumFinal;

  // partial products: opA gated by each bit of opB, placed at its weight
  for (genvar j = 0; j < PPR; j++) begin : g_pp
    if (j < M) begin : g_real
      assign ppRows[j] = ({W{opB[j]}} & W'(opA)) << j;
    end else begin : g_pad
      assign ppRows[j] = '0;
    end
  end

  // carry-save reduction levels
  for (genvar l = 0; l < LVLS; l++) begin : lvl
    localparam int NIN  = rowsAtLevel(PPR, l);
    localparam int NOUT = rowsAfter(NIN);
    localparam int GRP  = NIN / 3;
    localparam int LEFT = NIN - 3 * GRP;

    logic [W-1:0] rowsIn   [NIN];
    logic [W-1:0] rowsNext [NOUT];
    logic [W-1:0] rowsQ    [NOUT];

    for (genvar k = 0; k < NIN; k++) begin : g_in
      if (l == 0) begin : g_first
        assign rowsIn[k] = ppRows[k];
      end else begin : g_chain
        assign rowsIn[k] = lvl[l-1].rowsQ[k];
      end
    end

    for (genvar g = 0; g < GRP; g++) begin : g_grp
      wallace_csa #(.W(W)) u_csa (
        .inA     (rowsIn[3*g]),
        .inB     (rowsIn[3*g+1]),
        .inC     (rowsIn[3*g+2]),
        .sumRow  (rowsNext[2*g]),
        .carryRow(rowsNext[2*g+1])
      );
    end

    for (genvar k = 0; k < LEFT; k++) begin : g_pass
      assign rowsNext[2*GRP+k] = rowsIn[3*GRP+k];
    end

    if (PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int k = 0; k < NOUT; k++) rowsQ[k] <= '0;
        end else if (strobes.loadEn[l]) begin
          for (int k = 0; k < NOUT; k++) rowsQ[k] <= rowsNext[k];
        end
      end
    end else begin : g_wire
      for (genvar k = 0; k < NOUT; k++) begin : g_w
        assign rowsQ[k] = rowsNext[k];
      end
    end
  end

  // the only carry-propagate adder
  assign sumFinal = lvl[LVLS-1].rowsQ[0] + lvl[LVLS-1].rowsQ[1];

  if (PIPE) begin : g_outReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     product <= '0;
      else if (strobes.loadEn[LVLS]) product <= sumFinal;
    end
  end else begin : g_outWire
    assign product = sumFinal;
  end

endmodule

// File: rtl/wallace_ctrl.sv
module wallace_ctrl
  import wallace_pkg::*;
#(
  parameter int LVLS = 4,
  parameter bit PIPE = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    validIn,
  output strobe_t strobes,
  output logic    validOut
);

  logic [LVLS:0] validQ;

  // stage k loads when a qualified pair is entering it
  always_comb begin
    strobes = '0;
    strobes.loadEn[0] = validIn;
    for (int k = 1; k <= LVLS; k++) strobes.loadEn[k] = validQ[k-1];
  end

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= '0;
      else       validQ <= {validQ[LVLS-1:0], validIn};
    end
    assign validOut = validQ[LVLS];
  end else begin : g_comb
    assign validQ   = '0;
    assign validOut = validIn;
  end

endmodule

// File: rtl/wallace_mul.sv
module wallace_mul
  import wallace_pkg::*;
#(
  parameter int N    = 8,
  parameter int M    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           validIn,
  input  logic [N-1:0]   opA,
  input  logic [M-1:0]   opB,
  output logic           validOut,
  output logic [N+M-1:0] product
);

  localparam int LVLS = levelCount(padRows(M));

  strobe_t strobes;

  wallace_ctrl #(.LVLS(LVLS), .PIPE(PIPE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .strobes (strobes),
    .validOut(validOut)
  );

  wallace_datapath #(.N(N), .M(M), .PIPE(PIPE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .product(product)
  );

endmodule

// File: rtl/wallace_mul_chk.sv
module wallace_mul_chk
  import wallace_pkg::*;
#(
  parameter int N    = 8,
  parameter int M    = 8,
  parameter bit PIPE = 1'b1
) (
  input logic           clk,
  input logic           rstN,
  input logic           validIn,
  input logic [N-1:0]   opA,
  input logic [M-1:0]   opB,
  input logic           validOut,
  input logic [N+M-1:0] product
);

  localparam int W   = N + M;
  localparam int LAT = levelCount(padRows(M)) + 1;

  logic [W-1:0] refProd;
  assign refProd = W'(opA) * W'(opB);

  if (PIPE) begin : g_pipe
    logic [LAT-1:0] expV;
    logic [W-1:0]   expP [LAT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        expV <= '0;
        for (int i = 0; i < LAT; i++) expP[i] <= '0;
      end else begin
        expV    <= {expV[LAT-2:0], validIn};
        expP[0] <= refProd;
        for (int i = 1; i < LAT; i++) expP[i] <= expP[i-1];
      end
    end

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      validOut |-> product == expP[LAT-1]); // R1
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      validOut == expV[LAT-1]); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !validOut |-> $stable(product)); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
      !rstN |=> !validOut); // R5
  end else begin : g_comb
    AST_COMB_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
      product == refProd); // R6
    AST_COMB_VALID: assert property (@(posedge clk) disable iff (!rstN)
      validOut == validIn); // R6
  end

endmodule

bind wallace_mul wallace_mul_chk #(.N(N), .M(M), .PIPE(PIPE)) u_chk (.*);

// File: tb/test_wallace_mul.sv
module test_wallace_mul;

  localparam int N = 8;
  localparam int M = 8;
  localparam int W = N + M;

  // latency from the R2 rule: levels of 3:2 reduction plus the output stage
  function automatic int expectedLatency(input int m);
    int r;
    int n;
    r = (m < 3) ? 3 : m;
    n = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      n++;
    end
    return n + 1;
  endfunction

  localparam int LAT = expectedLatency(M);

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [N-1:0] opA = '0;
  logic [M-1:0] opB = '0;
  logic         validOut;
  logic [W-1:0] product;
  logic         combValid;
  logic [W-1:0] combProduct;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] lastProd = '0;

  always #4 clk = ~clk;

  wallace_mul #(.N(N), .M(M), .PIPE(1'b1)) i_wallace_mul (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opA(opA), .opB(opB),
    .validOut(validOut), .product(product)
  );

  wallace_mul #(.N(N), .M(M), .PIPE(1'b0)) i_wallace_mul_comb (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opA(opA), .opB(opB),
    .validOut(combValid), .product(combProduct)
  );

  task automatic checkVal(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkComb(input logic [N-1:0] a, input logic [M-1:0] b, input logic v);
    #1;
    checkVal("R6 comb product", combProduct, W'(a) * W'(b));
    checkVal("R6 comb valid", W'(combValid), W'(v));
  endtask

  // R5: reset state, held and just after release
  task automatic testReset();
    rstN = 1'b0;
    validIn = 1'b1;
    opA = 8'hff;
    opB = 8'hff;
    repeat (3) @(negedge clk);
    checkVal("R5 validOut in reset", W'(validOut), '0);
    checkVal("R5 product in reset", product, '0);
    validIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R5 validOut after release", W'(validOut), '0);
    checkVal("R5 product after release", product, '0);
    lastProd = '0;
  endtask

  // R1/R2/R4/R7: one pair, exact latency, then hold
  task automatic testSingle(input logic [N-1:0] a, input logic [M-1:0] b);
    logic [W-1:0] exp;
    exp = W'(a) * W'(b);
    @(negedge clk);
    opA = a;
    opB = b;
    validIn = 1'b1;
    checkComb(a, b, 1'b1);
    @(negedge clk);
    validIn = 1'b0;
    opA = ~a;
    opB = ~b;
    for (int i = 1; i < LAT; i++) begin
      checkVal("R2 validOut early", W'(validOut), '0);
      checkVal("R4 product held early", product, lastProd);
      @(negedge clk);
    end
    checkVal("R2 validOut at latency", W'(validOut), 1);
    checkVal("R1 product", product, exp);
    lastProd = exp;
    @(negedge clk);
    checkVal("R7 validOut after garbage", W'(validOut), '0);
    checkVal("R4 product held", product, exp);
  endtask

  // R3/R7: back-to-back stream with bubbles carrying garbage operands
  task automatic testStream(input int count, input int bubbleEvery);
    logic [W-1:0] expQ [64];
    logic         vQ   [64];
    for (int c = 0; c < count + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        if (vQ[c-LAT]) begin
          checkVal("R3 stream valid", W'(validOut), 1);
          checkVal("R3 stream product", product, expQ[c-LAT]);
          lastProd = expQ[c-LAT];
        end else begin
          checkVal("R7 bubble valid", W'(validOut), '0);
          checkVal("R7 bubble product held", product, lastProd);
        end
      end else begin
        checkVal("R2 stream startup", W'(validOut), '0);
      end
      if (c < count) begin
        opA = N'($urandom);
        opB = M'($urandom);
        if (c % 5 == 1) opA = '1;
        if (c % 7 == 2) opB = '0;
        vQ[c] = (bubbleEvery == 0) ? 1'b1 : ((c % bubbleEvery) != bubbleEvery - 1);
        validIn = vQ[c];
        expQ[c] = W'(opA) * W'(opB);
        checkComb(opA, opB, vQ[c]);
      end else begin
        validIn = 1'b0;
        opA = '0;
        opB = '0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    testReset();
    testSingle(8'h00, 8'h00);
    testSingle(8'hff, 8'hff);
    testSingle(8'hff, 8'h00);
    testSingle(8'h80, 8'h80);
    testSingle(8'h01, 8'h01);
    testSingle(8'h5a, 8'hc3);
    for (int k = 0; k < 8; k++) testSingle(8'(1 << k), 8'(1 << (7 - k)));
    for (int k = 0; k < 8; k++) testSingle(8'hff, 8'(1 << k));
    testStream(40, 0);
    testStream(50, 3);
    testStream(30, 4);
    testReset();
    testSingle(8'h7f, 8'h81);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule